// File: doc/BRIEF.md
# Two-Phase Watchdog Timer

This block is a watchdog timer with a 32-bit register interface. A free-running base divider turns the bus clock into base ticks of 2^TICK_EXP cycles. A logarithmic prescaler then stretches each tick by 1, 2, 4 or 8. The time allowed is spent in two counted phases.

When the first phase runs out, the block raises a pre-timeout interrupt. From that moment software can no longer turn the watchdog off. When the second phase then runs out, the block pulses one of three reset outputs for one cycle. The control register selects which one: whole chip, processor only, or a software-level reset.

Software enables the block once and then keeps it alive by writing a kick word before the first phase ends. If the kick never comes, the interrupt gives software one more period to react before the reset is issued. After the reset pulse the block falls back to its power-on configuration.

Top module: `wdt_two_phase`

## Requirements
- R1: After reset, the control register reads 0x00000001 (processor-reset mode, all other fields zero), the status register reads 0, and `irq_pre`, `rst_soc`, `rst_cpu` and `rst_sw` are all low.
- R2: Control register fields are: bit 31 enable, bits 30:29 scale exponent s, bits 26:22 first limit L1, bits 19:15 second limit L2, and bits 1:0 mode. Let B = 2^TICK_EXP. When enable is written at clock edge E, status bit 31 and `irq_pre` are set at edge E + (L1+1)·2^s·B.
- R3: The second phase ends at edge E + (L1+L2+2)·2^s·B. At that edge status bit 30 is set, and the selected reset output goes high for that cycle.
- R4: Mode 0 drives `rst_soc`, mode 1 drives `rst_cpu`, mode 2 drives `rst_sw`, and the reserved mode 3 drives `rst_soc`. At most one reset output is high at any time, and each pulse lasts exactly one cycle.
- R5: At the edge where the reset pulse is issued, the control register returns to 0x00000001 and the phase sequence goes back to its start. The status flags are kept.
- R6: Writing a word with bit 31 set to offset 0x0 is a kick. A kick during the first phase restarts timing, so the interrupt follows at kick edge K + (L1+1)·2^s·B.
- R7: A kick during the second phase has no effect on when the reset is issued.
- R8: Once the first phase has expired, writing enable to 0 does not stop the second phase or the reset.
- R9: While enable is 0 in the first phase, all counters are held at zero and no event is produced. A later enable starts the timing from zero.
- R10: The status register is at offset 0x4. Writing 1 to bit 31 or bit 30 clears that flag, and writing 0 leaves it unchanged. A flag being set in the same cycle wins over a clear. `irq_pre` follows bit 31.
- R11: With scale and both limits at zero, the interrupt comes 1·B cycles after enable and the reset comes 2·B cycles after enable.
- R12: Only word-aligned accesses (address bits 1:0 equal to zero) at offsets 0x0, 0x4 and 0x8 reach a register. Reads of the control register return only the defined fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_pre | output | 1 | Pre-timeout interrupt, level of status bit 31 |
| rst_soc | output | 1 | Whole-chip reset pulse |
| rst_cpu | output | 1 | Processor-only reset pulse |
| rst_sw | output | 1 | Software-level reset pulse |

## Verification
Three situations are hard to reach from the ports, because each one needs a register write to land inside a window bounded by timer expiries:
- a kick that arrives after the pre-timeout interrupt,
- an enable cleared after the lock has taken hold,
- a disable that happens part-way through the first phase.

The bench builds the block with a short base tick. It records the edge at which each enabling write or kick takes effect. It then schedules the next write at a cycle computed from that edge, so that the write falls clearly inside the intended phase. The expected interrupt and reset edges are computed from the field values and queued before they occur.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DATA_W  = 32;
    localparam int LIM_W   = 5;
    localparam int SCALE_W = 2;

    // Word index of each register (byte offset >> 2)
    localparam logic [1:0] IDX_KICK = 2'd0;
    localparam logic [1:0] IDX_STAT = 2'd1;
    localparam logic [1:0] IDX_CTRL = 2'd2;

    localparam int BIT_KICK  = 31;
    localparam int BIT_FLAG1 = 31;
    localparam int BIT_FLAG2 = 30;

    typedef enum logic [1:0] {
        MODE_SOC  = 2'd0,
        MODE_CPU  = 2'd1,
        MODE_SW   = 2'd2,
        MODE_RSVD = 2'd3
    } rst_mode_e;

    typedef enum logic {
        PH_ONE = 1'b0,
        PH_TWO = 1'b1
    } phase_e;

    typedef struct packed {
        logic               en;
        logic [SCALE_W-1:0] scale;
        logic [LIM_W-1:0]   lim1;
        logic [LIM_W-1:0]   lim2;
        rst_mode_e          mode;
    } ctrl_t;

    localparam ctrl_t CTRL_DEFAULT = '{en: 1'b0, scale: '0, lim1: '0, lim2: '0, mode: MODE_CPU};

    function automatic ctrl_t unpack_ctrl(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.en    = w[31];
        c.scale = w[30:29];
        c.lim1  = w[26:22];
        c.lim2  = w[19:15];
        c.mode  = rst_mode_e'(w[1:0]);
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
        return {c.en, c.scale, 2'b00, c.lim1, 2'b00, c.lim2, 13'd0, c.mode};
    endfunction

    // Returns {sw, cpu, soc}; reserved code falls back to the whole-chip reset
    function automatic logic [2:0] mode_select(input rst_mode_e m);
        case (m)
            MODE_CPU: return 3'b010;
            MODE_SW:  return 3'b100;
            default:  return 3'b001;
        endcase
    endfunction

endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
    parameter int TICK_EXP = 25,
    parameter int SCALE_W  = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               clr,
    input  logic [SCALE_W-1:0] scale,
    output logic               tick,
    output logic               idle
);
    localparam int PRE_W = (1 << SCALE_W) - 1;

    logic [TICK_EXP-1:0] base_cnt;
    logic [PRE_W-1:0]    pre_cnt;
    logic [PRE_W-1:0]    pre_last;
    logic                base_tick;

    assign pre_last  = (PRE_W'(1) << scale) - PRE_W'(1);
    assign base_tick = run && (&base_cnt);
    assign tick      = base_tick && (pre_cnt >= pre_last);
    assign idle      = (base_cnt == '0) && (pre_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            base_cnt <= '0;
            pre_cnt  <= '0;
        end else if (run) begin
            base_cnt <= base_cnt + 1'b1;
            if (base_tick) begin
                pre_cnt <= (pre_cnt >= pre_last) ? '0 : pre_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdt_phase_seq.sv
module wdt_phase_seq
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [LIM_W-1:0] lim1,
    input  logic [LIM_W-1:0] lim2,
    input  logic             tick,
    input  logic             kick,
    output phase_e           phase,
    output logic             run,
    output logic             clr,
    output logic             exp1,
    output logic             exp2,
    output logic             tcnt_zero
);
    logic [LIM_W-1:0] tcnt;
    logic             kick_ph1;
    logic             tick_ok;

    assign kick_ph1  = kick && (phase == PH_ONE);
    assign run       = en || (phase == PH_TWO);
    assign tick_ok   = tick && run && !kick_ph1;
    assign exp1      = tick_ok && (phase == PH_ONE) && (tcnt == lim1);
    assign exp2      = tick_ok && (phase == PH_TWO) && (tcnt == lim2);
    assign clr       = !run || kick_ph1 || exp2;
    assign tcnt_zero = (tcnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_ONE;
            tcnt  <= '0;
        end else begin
            if (exp1)      phase <= PH_TWO;
            else if (exp2) phase <= PH_ONE;

            if (clr)            tcnt <= '0;
            else if (tick_ok)   tcnt <= (exp1 || exp2) ? '0 : tcnt + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              exp1,
    input  logic              exp2,
    output ctrl_t             ctrl,
    output logic              flag1,
    output logic              flag2,
    output logic              kick,
    output logic [DATA_W-1:0] rdata
);
    localparam int IDX_W = ADDR_W - 2;

    logic             aligned;
    logic [IDX_W-1:0] idx;
    logic             sel_kick, sel_stat, sel_ctrl;

    assign aligned  = (addr[1:0] == 2'b00);
    assign idx      = addr[ADDR_W-1:2];
    assign sel_kick = aligned && (idx == IDX_W'(IDX_KICK));
    assign sel_stat = aligned && (idx == IDX_W'(IDX_STAT));
    assign sel_ctrl = aligned && (idx == IDX_W'(IDX_CTRL));

    assign kick = wr && sel_kick && wdata[BIT_KICK];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= CTRL_DEFAULT;
            flag1 <= 1'b0;
            flag2 <= 1'b0;
        end else begin
            if (exp2)                  ctrl <= CTRL_DEFAULT;
            else if (wr && sel_ctrl)   ctrl <= unpack_ctrl(wdata);

            if (exp1)                                  flag1 <= 1'b1;
            else if (wr && sel_stat && wdata[BIT_FLAG1]) flag1 <= 1'b0;

            if (exp2)                                  flag2 <= 1'b1;
            else if (wr && sel_stat && wdata[BIT_FLAG2]) flag2 <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (sel_stat) begin
            rdata[BIT_FLAG1] = flag1;
            rdata[BIT_FLAG2] = flag2;
        end else if (sel_ctrl) begin
            rdata = pack_ctrl(ctrl);
        end
    end
endmodule

// File: rtl/wdt_two_phase.sv
module wdt_two_phase
    import wdt_pkg::*;
#(
    parameter int TICK_EXP = 25,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_pre,
    output logic              rst_soc,
    output logic              rst_cpu,
    output logic              rst_sw
);
    ctrl_t   ctrl;
    phase_e  phase;
    logic    flag1, flag2, kick;
    logic    run, clr, tick, gen_idle, tcnt_zero;
    logic    exp1, exp2;
    logic    phase_two;
    logic [2:0] rst_q;

    wdt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .exp1  (exp1),
        .exp2  (exp2),
        .ctrl  (ctrl),
        .flag1 (flag1),
        .flag2 (flag2),
        .kick  (kick),
        .rdata (reg_rdata)
    );

    wdt_tick_gen #(.TICK_EXP(TICK_EXP), .SCALE_W(SCALE_W)) u_tick (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .clr   (clr),
        .scale (ctrl.scale),
        .tick  (tick),
        .idle  (gen_idle)
    );

    wdt_phase_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .en        (ctrl.en),
        .lim1      (ctrl.lim1),
        .lim2      (ctrl.lim2),
        .tick      (tick),
        .kick      (kick),
        .phase     (phase),
        .run       (run),
        .clr       (clr),
        .exp1      (exp1),
        .exp2      (exp2),
        .tcnt_zero (tcnt_zero)
    );

    assign phase_two = (phase == PH_TWO);

    always_ff @(posedge clk) begin
        if (rst)       rst_q <= '0;
        else if (exp2) rst_q <= mode_select(ctrl.mode);
        else           rst_q <= '0;
    end

    assign rst_soc = rst_q[0];
    assign rst_cpu = rst_q[1];
    assign rst_sw  = rst_q[2];
    assign irq_pre = flag1;
endmodule

// File: rtl/wdt_two_phase_chk.sv
module wdt_two_phase_chk (
    input logic clk,
    input logic rst,
    input logic rst_soc,
    input logic rst_cpu,
    input logic rst_sw,
    input logic flag2,
    input logic ctrl_en,
    input logic phase_two,
    input logic kick,
    input logic gen_idle,
    input logic tcnt_zero
);
    logic any_rst;
    assign any_rst = rst_soc || rst_cpu || rst_sw;

    p_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $countones({rst_soc, rst_cpu, rst_sw}) <= 1);

    p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        any_rst |=> !any_rst);

    p_flag_with_reset_r3: assert property (@(posedge clk) disable iff (rst)
        any_rst |-> flag2);

    p_default_after_reset_r5: assert property (@(posedge clk) disable iff (rst)
        any_rst |-> (!ctrl_en && !phase_two));

    p_locked_r8: assert property (@(posedge clk) disable iff (rst)
        phase_two |=> (phase_two || any_rst));

    p_kick_restart_r6: assert property (@(posedge clk) disable iff (rst)
        (kick && !phase_two) |=> (gen_idle && tcnt_zero));

    p_hold_when_off_r9: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_en && !phase_two) |=> (gen_idle && tcnt_zero));
endmodule

bind wdt_two_phase wdt_two_phase_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .rst_soc   (rst_soc),
    .rst_cpu   (rst_cpu),
    .rst_sw    (rst_sw),
    .flag2     (flag2),
    .ctrl_en   (ctrl.en),
    .phase_two (phase_two),
    .kick      (kick),
    .gen_idle  (gen_idle),
    .tcnt_zero (tcnt_zero)
);

// File: tb/wdt_two_phase_tb.sv
module wdt_two_phase_tb;
    localparam int TE = 2;
    localparam int B  = 1 << TE;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, soc, cpu, sw;

    wdt_two_phase #(.TICK_EXP(TE), .ADDR_W(4)) u_dut (
        .clk(clk), .rst(rst), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .irq_pre(irq), .rst_soc(soc), .rst_cpu(cpu), .rst_sw(sw)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    int    q_kind[$];
    int    q_cyc[$];
    string q_tag[$];

    function automatic logic [31:0] mk(logic en, logic [1:0] s, logic [4:0] l1, logic [4:0] l2, logic [1:0] m);
        return {en, s, 2'b00, l1, 2'b00, l2, 13'd0, m};
    endfunction

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic reg_write(logic [3:0] a, logic [31:0] d, output int edge_n);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 edge_n = cyc;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic reg_read(logic [3:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        addr = a;
        #1 chk(rdata == exp, tag, $sformatf("read @0x%0h", a), rdata, exp);
    endtask

    task automatic expect_evt(int kind, int at, string tag);
        q_kind.push_back(kind);
        q_cyc.push_back(at);
        q_tag.push_back(tag);
    endtask

    task automatic wait_until(int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic drain();
        while (q_kind.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_flags();
        int e;
        reg_write(4'h4, 32'hC000_0000, e);
    endtask

    // Monitor: 0 = interrupt rise, 1 = soc, 2 = cpu, 3 = sw reset
    logic irq_prev = 1'b0;
    int   ev_kind;
    int   ek, ec;
    string et;
    always @(negedge clk) begin
        if (!rst) begin
            ev_kind = -1;
            if (irq && !irq_prev) ev_kind = 0;
            else if (soc)         ev_kind = 1;
            else if (cpu)         ev_kind = 2;
            else if (sw)          ev_kind = 3;
            if (ev_kind >= 0) begin
                if (q_kind.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R9 unexpected event kind %0d at cycle %0d: actual event, expected none", ev_kind, cyc);
                end else begin
                    ek = q_kind.pop_front();
                    ec = q_cyc.pop_front();
                    et = q_tag.pop_front();
                    chk(ev_kind == ek, et, "event kind", ev_kind, ek);
                    chk(cyc == ec, et, "event cycle", cyc, ec);
                end
            end
        end
        irq_prev = irq;
    end

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired (all requirements): actual hung, expected done");
        finish_up();
    end

    initial begin
        int e, k, k2;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        reg_read(4'h8, 32'h0000_0001, "R1");
        reg_read(4'h4, 32'h0, "R1");
        chk({irq, soc, cpu, sw} == 4'b0, "R1", "outputs", {irq, soc, cpu, sw}, 0);

        // R11 / R2 / R3 / R4: shortest path, processor mode
        reg_write(4'h8, mk(1'b1, 2'd0, 5'd0, 5'd0, 2'd1), e);
        expect_evt(0, e + B, "R11 R2");
        expect_evt(2, e + 2 * B, "R11 R3 R4");
        drain();
        reg_read(4'h8, 32'h0000_0001, "R5");
        reg_read(4'h4, 32'hC000_0000, "R3");
        chk(irq == 1'b1, "R10", "irq level", irq, 1);

        // R10 write-one-to-clear
        reg_write(4'h4, 32'h0, e);
        reg_read(4'h4, 32'hC000_0000, "R10");
        reg_write(4'h4, 32'h8000_0000, e);
        reg_read(4'h4, 32'h4000_0000, "R10");
        chk(irq == 1'b0, "R10", "irq after clear", irq, 0);
        reg_write(4'h4, 32'h4000_0000, e);
        reg_read(4'h4, 32'h0, "R10");

        // R12 misaligned write is ignored; control readback shows defined fields only
        reg_write(4'h9, 32'hFFFF_FFFF, e);
        reg_read(4'h8, 32'h0000_0001, "R12");
        reg_write(4'h8, 32'h0000_0002, e);
        reg_read(4'h8, 32'h0000_0002, "R12");

        // R2 / R3 / R4 with scale, software reset
        reg_write(4'h8, mk(1'b1, 2'd2, 5'd2, 5'd1, 2'd2), e);
        expect_evt(0, e + 3 * 4 * B, "R2");
        expect_evt(3, e + 5 * 4 * B, "R3 R4");
        drain();
        clear_flags();

        // R6 kick in phase one, R7 kick in phase two, whole-chip mode
        reg_write(4'h8, mk(1'b1, 2'd0, 5'd3, 5'd3, 2'd0), e);
        wait_until(e + 6);
        reg_write(4'h0, 32'h8000_0000, k);
        expect_evt(0, k + 4 * B, "R6");
        expect_evt(1, k + 8 * B, "R7 R4");
        wait_until(k + 4 * B + 3);
        reg_write(4'h0, 32'h8000_0000, k2);
        drain();
        clear_flags();

        // R8 lock after pre-timeout, reserved mode -> whole chip
        reg_write(4'h8, mk(1'b1, 2'd0, 5'd1, 5'd3, 2'd3), e);
        expect_evt(0, e + 2 * B, "R8");
        expect_evt(1, e + 6 * B, "R8 R4");
        wait_until(e + 2 * B + 2);
        reg_write(4'h8, mk(1'b0, 2'd0, 5'd1, 5'd3, 2'd3), k);
        drain();
        clear_flags();

        // R9 disable in phase one holds, re-enable restarts from zero
        reg_write(4'h8, mk(1'b1, 2'd1, 5'd1, 5'd0, 2'd1), e);
        wait_until(e + 10);
        reg_write(4'h8, mk(1'b0, 2'd1, 5'd1, 5'd0, 2'd1), k);
        repeat (60) @(negedge clk);
        reg_read(4'h4, 32'h0, "R9");
        chk(irq == 1'b0, "R9", "irq while disabled", irq, 0);
        reg_write(4'h8, mk(1'b1, 2'd1, 5'd1, 5'd0, 2'd1), e);
        expect_evt(0, e + 2 * 2 * B, "R9");
        expect_evt(2, e + 3 * 2 * B, "R9 R4");
        drain();
        reg_read(4'h8, 32'h0000_0001, "R5");

        finish_up();
    end
endmodule